// File: doc/BRIEF.md
# Command-Register Serial Slave Interface

This block is the digital host port of a measurement front end. An external controller reaches four internal registers through a 3-wire synchronous serial link made up of a serial clock, a data input and a data output, plus an optional active-low select. Every exchange opens with an 8-bit command byte. That byte says whether the following transfer reads or writes, and which register it addresses. The block then shifts the register out, or captures new contents, most significant bit first. When the transfer is done it goes back to waiting for the next command byte.

The four registers are a read-only status byte, a 24-bit configuration word that drives the block's configuration output, an 8-bit decimation word that goes to the conversion filter, and a 16-bit conversion result loaded by the filter through a one-cycle strobe. An active-low ready output marks a result that has not been read yet. The serial pins are sampled by the fast system clock, through a synchronizer and edge detectors. If the controller loses track of its position in a frame, it can force the interface back into step by holding the data input high for a long run of serial clocks.

Top module: `cmdif_serial_slave`

## Requirements
- R1: After reset the configuration output is 000007h, the decimation output is 69, the ready output is high, the data output is not driven (dout_en low), and the interface is waiting for a command byte.
- R2: A command byte is taken MSB first. It is accepted only when its bits 7:6 are 00. Bit 3 selects read (1) or write (0), and bits 1:0 select the register: 00 status, 01 configuration, 10 decimation, 11 result. Bits 5:4 and 2 are don't-care. A rejected byte, or a write aimed at 00 or 11, is dropped, and the interface keeps waiting for a command.
- R3: A configuration write takes 24 data bits, MSB first, each sampled on a rising serial clock edge. The configuration output takes the new word once the 24th bit is captured, and does not change before that.
- R4: A decimation write takes 8 bits. Each completed write raises sf_load for exactly one system clock. A value below 13 is stored as 13.
- R5: A read shifts the selected register out MSB first. Each bit is presented after a falling serial clock edge and is valid at the following rising edge. After the last bit the interface waits for a command again.
- R6: dout_en is low, and the data output is high-impedance, whenever no read is shifting out.
- R7: The status register reads back with bit 7 set while an unread result is pending, and with all other bits 0.
- R8: A data strobe loads the result register and drives the ready output low on the next system clock.
- R9: A completed result read drives the ready output high. A further read while the ready output is high returns the same result.
- R10: A result read returns the value held when its command byte completed, even if a strobe arrives during the read. The ready output then stays low.
- R11: After 32 consecutive ones on the data input, the interface is waiting for a command byte at bit 0, and the 32nd bit is used for nothing else. The run count starts again from zero.
- R12: Raising the select aborts any transfer. A partial write is not committed, and the interface waits for a command once the select returns low.
- R13: A configuration write produces no sf_load pulse and leaves the ready output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller, idles high |
| din | input | 1 | Serial data in, sampled on rising sclk |
| cs_n | input | 1 | Active-low select; tie low if unused |
| data_strobe | input | 1 | One-cycle pulse: a new conversion result is on data_in |
| data_in | input | 16 | Conversion result from the filter |
| dout | output | 1 | Serial data out, high-impedance when not reading |
| dout_en | output | 1 | High while dout is driven |
| rdy_n | output | 1 | Low while an unread result is held |
| cfg_out | output | 24 | Current configuration word |
| sf_out | output | 8 | Current decimation word |
| sf_load | output | 1 | One-cycle pulse after a decimation write |

## Verification
The bench attacks framing first. Thirty-two ones arrive in the middle of a configuration write, so the write completes with ones, two rejected command bytes follow, and the run ends two bits into a third byte. A design that did not realign would read back the next configuration register shifted by two bits. A strobe fired halfway through a result read must not leak into the shifted bits or release the ready output. Without the command-time snapshot the read would return a mixed word, and without the newer-result tracking the fresh result would be lost behind a high ready output. The bench also sends rejected command bytes, writes to read-only addresses, an aborting select and a decimation value below the floor. Each of these would leave the next read misaligned, or leave a register corrupted, if handled wrongly.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_e;

  localparam int CMD_W       = 8;
  localparam int CMD_RW_BIT  = 3;

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_CFG  = 2'd1;
  localparam logic [1:0] A_SF   = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  // A command is accepted only when its two top bits are clear.
  function automatic logic cmd_valid(logic [CMD_W-1:0] c);
    return c[CMD_W-1 -: 2] == 2'b00;
  endfunction

  function automatic logic cmd_is_read(logic [CMD_W-1:0] c);
    return c[CMD_RW_BIT];
  endfunction

  function automatic logic [1:0] cmd_addr(logic [CMD_W-1:0] c);
    return c[1:0];
  endfunction

  function automatic logic addr_writable(logic [1:0] a);
    return (a == A_CFG) || (a == A_SF);
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cmdif_sync.sv
module cmdif_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], d_in[b]};
    end
    assign q[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/cmdif_serial_engine.sv
module cmdif_serial_engine
  import cmdif_pkg::*;
#(
  parameter int STAT_W     = 8,
  parameter int CFG_W      = 24,
  parameter int SF_W       = 8,
  parameter int DATA_W     = 16,
  parameter int ONES_LIMIT = 32,
  parameter int SHIFT_W    = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               din_s,
  input  logic               sel_s,
  input  logic [SHIFT_W-1:0] rd_word,
  output logic [1:0]         rd_addr,
  output logic               start_rd,
  output logic               wr_last,
  output logic [1:0]         xfer_addr,
  output logic [SHIFT_W-1:0] wr_word,
  output logic               rd_last,
  output logic               ones_hit,
  output logic               cmd_idle,
  output logic               dout_bit,
  output logic               dout_en
);

  localparam int CNT_W  = $clog2(SHIFT_W + 1);
  localparam int ONES_W = $clog2(ONES_LIMIT + 1);
  localparam logic [CNT_W-1:0]  CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [ONES_W-1:0] ONES_LAST = ONES_W'(ONES_LIMIT - 1);

  function automatic logic [CNT_W-1:0] width_of(logic [1:0] a);
    case (a)
      A_STAT:  return CNT_W'(STAT_W);
      A_CFG:   return CNT_W'(CFG_W);
      A_SF:    return CNT_W'(SF_W);
      default: return CNT_W'(DATA_W);
    endcase
  endfunction

  phase_e              phase_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [ONES_W-1:0]   ones_q;
  logic [CMD_W-2:0]    cmd_q;
  logic [1:0]          addr_q;
  logic [SHIFT_W-1:0]  shreg_q;
  logic                dout_q;
  logic                sclk_q;

  logic                rise, fall, step;
  logic [CMD_W-1:0]    next_cmd;
  logic                cmd_end, start_wr;
  logic [CNT_W-1:0]    cur_last;
  logic [CNT_W-1:0]    pad;

  assign rise     = sel_s &  sclk_s & ~sclk_q;
  assign fall     = sel_s & ~sclk_s &  sclk_q;
  assign ones_hit = rise & din_s & (ones_q == ONES_LAST);
  assign step     = rise & ~ones_hit;

  assign next_cmd = {cmd_q, din_s};
  assign rd_addr  = cmd_addr(next_cmd);
  assign cmd_end  = step && (phase_q == PH_CMD) && (cnt_q == CMD_LAST) && cmd_valid(next_cmd);
  assign start_rd = cmd_end &&  cmd_is_read(next_cmd);
  assign start_wr = cmd_end && !cmd_is_read(next_cmd) && addr_writable(rd_addr);
  assign pad      = CNT_W'(SHIFT_W) - width_of(rd_addr);

  assign cur_last  = width_of(addr_q) - 1'b1;
  assign wr_last   = step && (phase_q == PH_WR) && (cnt_q == cur_last);
  assign rd_last   = step && (phase_q == PH_RD) && (cnt_q == cur_last);
  assign xfer_addr = addr_q;
  assign wr_word   = {shreg_q[SHIFT_W-2:0], din_s};

  assign cmd_idle  = (phase_q == PH_CMD) && (cnt_q == '0);
  assign dout_en   = sel_s && (phase_q == PH_RD);
  assign dout_bit  = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      ones_q  <= '0;
      cmd_q   <= '0;
      addr_q  <= A_STAT;
      shreg_q <= '0;
      dout_q  <= 1'b0;
      sclk_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      if (!sel_s || ones_hit) begin
        phase_q <= PH_CMD;
        cnt_q   <= '0;
        ones_q  <= '0;
      end else if (rise) begin
        ones_q <= din_s ? ones_q + 1'b1 : '0;
        unique case (phase_q)
          PH_CMD: begin
            cmd_q <= next_cmd[CMD_W-2:0];
            if (cnt_q == CMD_LAST) begin
              cnt_q  <= '0;
              addr_q <= rd_addr;
              if (start_rd) begin
                phase_q <= PH_RD;
                shreg_q <= rd_word << pad;
              end else if (start_wr) begin
                phase_q <= PH_WR;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_WR: begin
            shreg_q <= wr_word;
            if (wr_last) begin
              phase_q <= PH_CMD;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_RD: begin
            if (rd_last) begin
              phase_q <= PH_CMD;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: phase_q <= PH_CMD;
        endcase
      end else if (fall && (phase_q == PH_RD)) begin
        dout_q  <= shreg_q[SHIFT_W-1];
        shreg_q <= shreg_q << 1;
      end
    end
  end

endmodule

// File: rtl/cmdif_regbank.sv
module cmdif_regbank
  import cmdif_pkg::*;
#(
  parameter int              STAT_W  = 8,
  parameter int              CFG_W   = 24,
  parameter int              SF_W    = 8,
  parameter int              DATA_W  = 16,
  parameter int              SHIFT_W = 24,
  parameter logic [CFG_W-1:0] CFG_RST = 24'h000007,
  parameter int              SF_RST  = 69,
  parameter int              SF_MIN  = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_strobe,
  input  logic [DATA_W-1:0]  data_in,
  input  logic [1:0]         rd_addr,
  input  logic               start_rd,
  input  logic               wr_last,
  input  logic               rd_last,
  input  logic [1:0]         xfer_addr,
  input  logic [SHIFT_W-1:0] wr_word,
  output logic [SHIFT_W-1:0] rd_word,
  output logic [CFG_W-1:0]   cfg_out,
  output logic [SF_W-1:0]    sf_out,
  output logic               sf_load,
  output logic               rdy_n,
  output logic               ev_cfg_wr,
  output logic               ev_sf_wr,
  output logic               ev_rd_data_done
);

  logic [CFG_W-1:0]  cfg_q;
  logic [SF_W-1:0]   sf_q;
  logic [DATA_W-1:0] data_q;
  logic              pend_q;
  logic              newer_q;
  logic              sf_load_q;
  logic [SF_W-1:0]   sf_wr_val;

  function automatic logic [SF_W-1:0] floor_sf(logic [SF_W-1:0] v);
    return (v < SF_W'(SF_MIN)) ? SF_W'(SF_MIN) : v;
  endfunction

  assign ev_cfg_wr       = wr_last && (xfer_addr == A_CFG);
  assign ev_sf_wr        = wr_last && (xfer_addr == A_SF);
  assign ev_rd_data_done = rd_last && (xfer_addr == A_DATA);
  assign sf_wr_val       = floor_sf(wr_word[SF_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= CFG_RST;
      sf_q      <= SF_W'(SF_RST);
      data_q    <= '0;
      pend_q    <= 1'b0;
      newer_q   <= 1'b0;
      sf_load_q <= 1'b0;
    end else begin
      sf_load_q <= ev_sf_wr;
      if (ev_cfg_wr) cfg_q <= wr_word[CFG_W-1:0];
      if (ev_sf_wr)  sf_q  <= sf_wr_val;
      if (data_strobe) begin
        data_q  <= data_in;
        pend_q  <= 1'b1;
        newer_q <= 1'b1;
      end else begin
        if (start_rd && (rd_addr == A_DATA)) newer_q <= 1'b0;
        if (ev_rd_data_done && !newer_q)     pend_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    case (rd_addr)
      A_STAT:  rd_word[STAT_W-1] = pend_q;
      A_CFG:   rd_word[CFG_W-1:0]  = cfg_q;
      A_SF:    rd_word[SF_W-1:0]   = sf_q;
      default: rd_word[DATA_W-1:0] = data_q;
    endcase
  end

  assign cfg_out = cfg_q;
  assign sf_out  = sf_q;
  assign sf_load = sf_load_q;
  assign rdy_n   = ~pend_q;

endmodule

// File: rtl/cmdif_serial_slave.sv
module cmdif_serial_slave
  import cmdif_pkg::*;
#(
  parameter int               STAT_W      = 8,
  parameter int               CFG_W       = 24,
  parameter int               SF_W        = 8,
  parameter int               DATA_W      = 16,
  parameter logic [CFG_W-1:0] CFG_RST     = 24'h000007,
  parameter int               SF_RST      = 69,
  parameter int               SF_MIN      = 13,
  parameter int               ONES_LIMIT  = 32,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              cs_n,
  input  logic              data_strobe,
  input  logic [DATA_W-1:0] data_in,
  output logic              dout,
  output logic              dout_en,
  output logic              rdy_n,
  output logic [CFG_W-1:0]  cfg_out,
  output logic [SF_W-1:0]   sf_out,
  output logic              sf_load
);

  localparam int SHIFT_W = max_of(max_of(STAT_W, CFG_W), max_of(SF_W, DATA_W));

  logic [2:0]         pins_s;
  logic               sclk_s, din_s, sel_s;
  logic [SHIFT_W-1:0] rd_word, wr_word;
  logic [1:0]         rd_addr, xfer_addr;
  logic               start_rd, wr_last, rd_last;
  logic               ones_hit, cmd_idle, dout_bit;
  logic               ev_cfg_wr, ev_sf_wr, ev_rd_data_done;

  // Bit 2 = select (idles deselected), bit 1 = data, bit 0 = serial clock (idles high).
  cmdif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({cs_n, din, sclk}),
    .q     (pins_s)
  );

  assign sclk_s = pins_s[0];
  assign din_s  = pins_s[1];
  assign sel_s  = ~pins_s[2];

  cmdif_serial_engine #(
    .STAT_W(STAT_W), .CFG_W(CFG_W), .SF_W(SF_W), .DATA_W(DATA_W),
    .ONES_LIMIT(ONES_LIMIT), .SHIFT_W(SHIFT_W)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .din_s     (din_s),
    .sel_s     (sel_s),
    .rd_word   (rd_word),
    .rd_addr   (rd_addr),
    .start_rd  (start_rd),
    .wr_last   (wr_last),
    .xfer_addr (xfer_addr),
    .wr_word   (wr_word),
    .rd_last   (rd_last),
    .ones_hit  (ones_hit),
    .cmd_idle  (cmd_idle),
    .dout_bit  (dout_bit),
    .dout_en   (dout_en)
  );

  cmdif_regbank #(
    .STAT_W(STAT_W), .CFG_W(CFG_W), .SF_W(SF_W), .DATA_W(DATA_W),
    .SHIFT_W(SHIFT_W), .CFG_RST(CFG_RST), .SF_RST(SF_RST), .SF_MIN(SF_MIN)
  ) u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .data_strobe     (data_strobe),
    .data_in         (data_in),
    .rd_addr         (rd_addr),
    .start_rd        (start_rd),
    .wr_last         (wr_last),
    .rd_last         (rd_last),
    .xfer_addr       (xfer_addr),
    .wr_word         (wr_word),
    .rd_word         (rd_word),
    .cfg_out         (cfg_out),
    .sf_out          (sf_out),
    .sf_load         (sf_load),
    .rdy_n           (rdy_n),
    .ev_cfg_wr       (ev_cfg_wr),
    .ev_sf_wr        (ev_sf_wr),
    .ev_rd_data_done (ev_rd_data_done)
  );

  assign dout = dout_en ? dout_bit : 1'bz;

endmodule

// File: rtl/cmdif_checker.sv
module cmdif_checker #(
  parameter int CFG_W  = 24,
  parameter int SF_W   = 8,
  parameter int SF_MIN = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_strobe,
  input logic             dout_en,
  input logic             rdy_n,
  input logic [CFG_W-1:0] cfg_out,
  input logic [SF_W-1:0]  sf_out,
  input logic             sf_load,
  input logic             sel_s,
  input logic             ones_hit,
  input logic             cmd_idle,
  input logic             ev_cfg_wr,
  input logic             ev_sf_wr,
  input logic             ev_rd_data_done
);

  assert_sf_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sf_out >= SF_W'(SF_MIN));

  assert_load_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sf_load |=> !sf_load);

  assert_load_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sf_load) |-> $past(ev_sf_wr));

  assert_cfg_only_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_out) |-> $past(ev_cfg_wr));

  assert_cfg_no_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cfg_wr |=> !sf_load);

  assert_strobe_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_strobe |=> !rdy_n);

  assert_ready_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n) |-> $past(ev_rd_data_done));

  assert_ones_realign_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ones_hit |=> (cmd_idle && !dout_en));

  assert_deselect_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> (cmd_idle && !dout_en));

endmodule

bind cmdif_serial_slave cmdif_checker #(
  .CFG_W(CFG_W), .SF_W(SF_W), .SF_MIN(SF_MIN)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .data_strobe     (data_strobe),
  .dout_en         (dout_en),
  .rdy_n           (rdy_n),
  .cfg_out         (cfg_out),
  .sf_out          (sf_out),
  .sf_load         (sf_load),
  .sel_s           (sel_s),
  .ones_hit        (ones_hit),
  .cmd_idle        (cmd_idle),
  .ev_cfg_wr       (ev_cfg_wr),
  .ev_sf_wr        (ev_sf_wr),
  .ev_rd_data_done (ev_rd_data_done)
);

// File: tb/cmdif_serial_slave_tb.sv
module cmdif_serial_slave_tb;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic        cs_n = 1'b1;
  logic        data_strobe = 1'b0;
  logic [15:0] data_in = '0;
  wire         dout;
  logic        dout_en;
  logic        rdy_n;
  logic [23:0] cfg_out;
  logic [7:0]  sf_out;
  logic        sf_load;

  cmdif_serial_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .cs_n(cs_n),
    .data_strobe(data_strobe), .data_in(data_in), .dout(dout),
    .dout_en(dout_en), .rdy_n(rdy_n), .cfg_out(cfg_out), .sf_out(sf_out),
    .sf_load(sf_load)
  );

  always #2 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  int loads_seen = 0;

  always @(posedge clk) if (sf_load) loads_seen++;

  // Behavioural reference state
  int          m_phase = 0;   // 0 command, 1 write, 2 read
  int          m_cnt = 0, m_ones = 0, m_w = 0, m_addr = 0;
  logic [7:0]  m_cmd = '0;
  logic [31:0] m_acc = '0, m_snap = '0;
  logic [23:0] m_cfg = 24'h000007;
  int          m_sf = 69;
  logic [15:0] m_data = '0;
  bit          m_pend = 0, m_newer = 0;
  int          m_loads = 0;
  logic [31:0] rd_cap = '0;

  function automatic int reg_len(int a);
    case (a)
      1: return 24;
      3: return 16;
      default: return 8;
    endcase
  endfunction

  function automatic logic [31:0] reg_val(int a);
    case (a)
      0: return m_pend ? 32'h80 : 32'h0;
      1: return {8'h0, m_cfg};
      2: return m_sf;
      default: return {16'h0, m_data};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_rise(input logic b);
    if (b && m_ones == 31) begin
      m_phase = 0; m_cnt = 0; m_ones = 0;
      return;
    end
    m_ones = b ? m_ones + 1 : 0;
    case (m_phase)
      0: begin
        m_cmd = {m_cmd[6:0], b};
        m_cnt++;
        if (m_cnt == 8) begin
          m_cnt = 0;
          if (m_cmd[7:6] == 2'b00) begin
            m_addr = int'(m_cmd[1:0]);
            m_w = reg_len(m_addr);
            if (m_cmd[3]) begin
              m_phase = 2;
              m_snap = reg_val(m_addr);
              if (m_addr == 3) m_newer = 0;
            end else if (m_addr == 1 || m_addr == 2) begin
              m_phase = 1;
              m_acc = '0;
            end
          end
        end
      end
      1: begin
        m_acc = (m_acc << 1) | {31'b0, b};
        m_cnt++;
        if (m_cnt == m_w) begin
          if (m_addr == 1) m_cfg = m_acc[23:0];
          else begin
            m_sf = (m_acc[7:0] < 8'd13) ? 13 : int'(m_acc[7:0]);
            m_loads++;
          end
          m_phase = 0; m_cnt = 0;
        end
      end
      default: begin
        m_cnt++;
        if (m_cnt == m_w) begin
          if (m_addr == 3 && !m_newer) m_pend = 0;
          m_phase = 0; m_cnt = 0;
        end
      end
    endcase
  endtask

  // One serial clock period; compares the design with the model every bit.
  task automatic xbit(input logic b);
    @(negedge clk);
    sclk = 1'b0; din = b;
    repeat (HALF) @(negedge clk);
    if (m_phase == 2) begin
      chk("R5 dout enabled during read", {31'b0, dout_en}, 32'd1);
      chk("R5 serial bit", {31'b0, dout}, {31'b0, m_snap[m_w-1-m_cnt]});
      rd_cap = {rd_cap[30:0], dout};
    end else begin
      chk("R6 dout idle", {31'b0, dout_en}, 32'd0);
    end
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    model_rise(b);
    chk("R3 cfg_out", {8'h0, cfg_out}, {8'h0, m_cfg});
    chk("R4 sf_out", {24'h0, sf_out}, m_sf);
    chk("R4 sf_load count", loads_seen, m_loads);
    chk("R9 rdy_n", {31'b0, rdy_n}, {31'b0, !m_pend});
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) xbit(v[i]);
  endtask

  task automatic rd_bits(input int n);
    rd_cap = '0;
    for (int i = 0; i < n; i++) xbit(1'b0);
  endtask

  task automatic strobe(input logic [15:0] v);
    @(negedge clk);
    data_strobe = 1'b1; data_in = v;
    @(negedge clk);
    data_strobe = 1'b0;
    m_data = v; m_pend = 1; m_newer = 1;
    chk("R8 rdy_n low after strobe", {31'b0, rdy_n}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);

    // R1 reset state
    chk("R1 cfg reset", {8'h0, cfg_out}, 32'h000007);
    chk("R1 sf reset", {24'h0, sf_out}, 32'd69);
    chk("R1 rdy_n reset", {31'b0, rdy_n}, 32'd1);
    chk("R1 dout idle", {31'b0, dout_en}, 32'd0);

    // R3 configuration write, R5 read back, R13 no sf_load
    send(32'h01, 8); send(32'hA5C3F0, 24);
    chk("R3 cfg written", {8'h0, cfg_out}, 32'hA5C3F0);
    chk("R13 no sf_load on cfg write", loads_seen, 0);
    send(32'h09, 8); rd_bits(24);
    chk("R5 cfg readback", rd_cap, 32'hA5C3F0);

    // R4 decimation write, pulse and floor
    send(32'h02, 8); send(32'h52, 8);
    chk("R4 sf written", {24'h0, sf_out}, 32'h52);
    chk("R4 one pulse", loads_seen, 1);
    send(32'h0A, 8); rd_bits(8);
    chk("R5 sf readback", rd_cap, 32'h52);
    send(32'h02, 8); send(32'h05, 8);
    chk("R4 sf floor", {24'h0, sf_out}, 32'd13);

    // R7 status with nothing pending
    send(32'h08, 8); rd_bits(8);
    chk("R7 status idle", rd_cap, 32'h00);

    // R8/R7/R9 result path
    strobe(16'h1234);
    send(32'h08, 8); rd_bits(8);
    chk("R7 status pending", rd_cap, 32'h80);
    send(32'h0B, 8); rd_bits(16);
    chk("R9 data read", rd_cap, 32'h1234);
    chk("R9 rdy_n high after read", {31'b0, rdy_n}, 32'd1);
    send(32'h0B, 8); rd_bits(16);
    chk("R9 data re-read", rd_cap, 32'h1234);

    // R10 strobe during read
    strobe(16'hBEEF);
    send(32'h0B, 8);
    rd_cap = '0;
    for (int i = 0; i < 5; i++) xbit(1'b0);
    strobe(16'h0F0F);
    for (int i = 0; i < 11; i++) xbit(1'b0);
    chk("R10 snapshot kept", rd_cap, 32'hBEEF);
    chk("R10 rdy_n stays low", {31'b0, rdy_n}, 32'd0);
    send(32'h0B, 8); rd_bits(16);
    chk("R10 newer result", rd_cap, 32'h0F0F);

    // R2 rejected commands, read-only writes and don't-care bits
    send(32'hC9, 8);
    send(32'h00, 8);
    send(32'h03, 8);
    chk("R2 rejected keeps idle", {31'b0, dout_en}, 32'd0);
    send(32'h39, 8); rd_bits(24);
    chk("R2 don't-care bits read cfg", rd_cap, 32'hA5C3F0);

    // R11 ones run realigns mid-frame
    send(32'h01, 8); send(32'h2AA, 10);
    for (int i = 0; i < 32; i++) xbit(1'b1);
    chk("R11 cfg filled by ones", {8'h0, cfg_out}, {8'h0, m_cfg});
    send(32'h09, 8); rd_bits(24);
    chk("R11 aligned after ones", rd_cap, {8'h0, m_cfg});

    // R12 select abort
    send(32'h01, 8); send(32'h15, 6);
    @(negedge clk); cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    chk("R12 dout off when deselected", {31'b0, dout_en}, 32'd0);
    m_phase = 0; m_cnt = 0; m_ones = 0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    send(32'h09, 8); rd_bits(24);
    chk("R12 partial write dropped", rd_cap, {8'h0, m_cfg});

    // R13 cfg write leaves rdy_n and sf_load alone
    strobe(16'h5555);
    send(32'h01, 8); send(32'h123456, 24);
    chk("R13 rdy_n unchanged", {31'b0, rdy_n}, 32'd0);
    chk("R13 sf_load count", loads_seen, m_loads);
    chk("R6 idle at end", {31'b0, dout_en}, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule